// File: doc/BRIEF.md
# Serial Flash Page Program Controller

This block writes between 1 and 256 bytes into one page of a serial NOR flash over a four-wire SPI link in mode 0. A single start pulse supplies a 24-bit target address and a byte count. The block then runs three chip-select frames in order. The first frame is a lone write-enable command. The second is the page program frame: an opcode, three address bytes, and the payload bytes. The third reads the status register continuously until the flash reports that its internal write has ended. Only after that third frame closes does the block report completion.

Payload bytes come from an on-chip byte source through a request/valid handshake, so a ROM or FIFO can feed the frame at its own pace. The serial clock simply pauses while a byte is outstanding. Counts of zero or above one page are refused before any frame starts. A cycle-based limit stops the status polling if the flash stays busy too long, and the block reports an error in that case.

Target devices accept the address as given and wrap within the page when the low address byte is nonzero. The controller forwards such addresses unchanged. The page must have been erased beforehand, because programming can only clear bits.

Top module: `spf_page_writer`

## Requirements
- R1: While reset is active and after it is released, chip select is high, the serial clock is low, and busy, done, both error flags and the byte request are low.
- R2: A start with a byte count of 0 or greater than 256 makes done and the count error flag high in the cycle after start is sampled. No chip-select frame is opened and busy stays low.
- R3: An accepted start first opens a frame holding exactly one byte, 06h. Chip select rises at the same clock edge at which the serial clock falls after the eighth bit.
- R4: The second frame carries 02h, then the three address bytes most significant first and unmodified, then exactly `count` payload bytes in source order. A flash that wraps within the page therefore ends up holding the payload at offsets (low address byte + i) mod 256 of the addressed page.
- R5: A payload byte is taken in a cycle where both the byte request and valid are high. The request is raised only inside the program frame, and exactly `count` bytes are taken per operation.
- R6: The serial clock is low whenever chip select is high. Each high phase lasts one clock cycle and each low phase at least one. MOSI changes only while the serial clock is low, most significant bit first.
- R7: The third frame sends 05h and then clocks status bytes back to back, with bit 0 as the busy flag, which is the last bit of each byte. The frame ends at the first status byte whose bit 0 is 0, and chip select rises in the same cycle that done is pulsed.
- R8: If a status byte ends with bit 0 still 1 after at least TIMEOUT_CYC cycles of polling, the block closes the frame and pulses done with the timeout error flag set.
- R9: A start pulse that arrives while an operation is in progress is ignored. It raises no error and does not change the frames being sent.
- R10: Busy is high from the edge that accepts a start until the edge that raises done. Busy is low in the done cycle, and done lasts exactly one cycle per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; serial clock runs at half this rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an operation (sampled only when idle) |
| start_addr | input | 24 | Target flash address |
| byte_count | input | 9 | Number of payload bytes, 1 to 256 |
| src_req | output | 1 | Request for the next payload byte |
| src_vld | input | 1 | Payload byte valid; transfer when high with src_req |
| src_data | input | 8 | Payload byte |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_count | output | 1 | Count rejected; valid with done |
| err_timeout | output | 1 | Status polling timed out; valid with done |

## Verification
A sequencer stuck in the wrong state shows at the flash pins within one byte time. The symptoms are a frame with the wrong bit length, a missing gap between frames, or a third frame that never closes. The flash model counts bits per frame and decodes every byte, so a skipped or repeated address or payload byte shows up when that frame ends. A wrong shift counter or phase appears first as serial clock pulses with the wrong width or as MOSI moving while the clock is high. Polling that misreads the busy bit or stops early shows as done arriving before the model's busy time has run out, or much later than it.

// File: rtl/spf_pkg.sv
package spf_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_BYTES = 3;
  // Command bytes sent to the flash
  localparam logic [BYTE_W-1:0] OPC_WREN = 8'h06;
  localparam logic [BYTE_W-1:0] OPC_PROG = 8'h02;
  localparam logic [BYTE_W-1:0] OPC_RDSR = 8'h05;
  localparam logic [BYTE_W-1:0] OPC_FILL = 8'h00;
  // The busy flag is status bit 0, i.e. the last bit shifted in per byte

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WEN_OP,
    ST_WEN_BIT,
    ST_GAP_A,
    ST_PP_OP,
    ST_PP_HDR,
    ST_PP_REQ,
    ST_PP_BIT,
    ST_GAP_B,
    ST_RS_OP,
    ST_RS_CMD,
    ST_RS_POLL
  } spf_state_e;
endpackage

// File: rtl/spf_down_counter.sv
module spf_down_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] value_i,
  input  logic         en_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = value_i;
    end else if (en_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/spf_bit_engine.sv
module spf_bit_engine #(
  parameter int WORD_W = 8,
  localparam int CW = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              last_o
);
  logic [WORD_W-1:0] sr_q, sr_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              ph_q, ph_d;
  logic              act_q, act_d;
  logic              sck_q, sck_d;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    ph_d  = ph_q;
    act_d = act_q;
    sck_d = sck_q;
    if (act_q) begin
      if (!ph_q) begin
        sck_d = 1'b1;
        ph_d  = 1'b1;
      end else begin
        sck_d = 1'b0;
        ph_d  = 1'b0;
        sr_d  = {sr_q[WORD_W-2:0], 1'b0};
        if (cnt_q == '0) begin
          act_d = 1'b0;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
    end
    if (load_i) begin
      sr_d  = data_i;
      cnt_d = CW'(WORD_W - 1);
      ph_d  = 1'b0;
      act_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
      ph_q  <= 1'b0;
      act_q <= 1'b0;
      sck_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
      act_q <= act_d;
      sck_q <= sck_d;
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = sr_q[WORD_W-1];
  assign last_o = act_q & ph_q & (cnt_q == '0);
endmodule

// File: rtl/spf_seq_ctrl.sv
module spf_seq_ctrl
  import spf_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  localparam int CNT_W  = $clog2(PAGE_BYTES) + 1,
  localparam int ADDR_W = ADDR_BYTES * BYTE_W,
  localparam int HIDX_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              vld_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              miso_i,
  input  logic              eng_last_i,
  input  logic              gap_zero_i,
  input  logic              to_zero_i,
  output logic              eng_load_o,
  output logic [BYTE_W-1:0] eng_data_o,
  output logic              gap_load_o,
  output logic              to_load_o,
  output logic              req_o,
  output logic              cs_n_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              errc_o,
  output logic              errt_o
);
  spf_state_e        st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  sent_q, sent_d;
  logic [HIDX_W-1:0] hidx_q, hidx_d;
  logic              cs_q, cs_d;
  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic              errc_q, errc_d;
  logic              errt_q, errt_d;

  always_comb begin
    st_d       = st_q;
    addr_d     = addr_q;
    cnt_d      = cnt_q;
    sent_d     = sent_q;
    hidx_d     = hidx_q;
    cs_d       = cs_q;
    busy_d     = busy_q;
    done_d     = 1'b0;
    errc_d     = 1'b0;
    errt_d     = 1'b0;
    eng_load_o = 1'b0;
    eng_data_o = OPC_FILL;
    gap_load_o = 1'b0;
    to_load_o  = 1'b0;
    req_o      = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if ((count_i == '0) || (count_i > CNT_W'(PAGE_BYTES))) begin
            done_d = 1'b1;
            errc_d = 1'b1;
          end else begin
            addr_d = addr_i;
            cnt_d  = count_i;
            sent_d = '0;
            busy_d = 1'b1;
            cs_d   = 1'b0;
            st_d   = ST_WEN_OP;
          end
        end
      end
      ST_WEN_OP: begin
        eng_load_o = 1'b1;
        eng_data_o = OPC_WREN;
        st_d       = ST_WEN_BIT;
      end
      ST_WEN_BIT: begin
        if (eng_last_i) begin
          cs_d       = 1'b1;
          gap_load_o = 1'b1;
          st_d       = ST_GAP_A;
        end
      end
      ST_GAP_A: begin
        if (gap_zero_i) begin
          cs_d = 1'b0;
          st_d = ST_PP_OP;
        end
      end
      ST_PP_OP: begin
        eng_load_o = 1'b1;
        eng_data_o = OPC_PROG;
        hidx_d     = '0;
        st_d       = ST_PP_HDR;
      end
      ST_PP_HDR: begin
        if (eng_last_i) begin
          if (hidx_q == HIDX_W'(ADDR_BYTES)) begin
            st_d = ST_PP_REQ;
          end else begin
            eng_load_o = 1'b1;
            eng_data_o = addr_q[ADDR_W-1 -: BYTE_W];
            addr_d     = addr_q << BYTE_W;
            hidx_d     = hidx_q + HIDX_W'(1);
          end
        end
      end
      ST_PP_REQ: begin
        req_o = 1'b1;
        if (vld_i) begin
          eng_load_o = 1'b1;
          eng_data_o = data_i;
          sent_d     = sent_q + CNT_W'(1);
          st_d       = ST_PP_BIT;
        end
      end
      ST_PP_BIT: begin
        if (eng_last_i) begin
          if (sent_q == cnt_q) begin
            cs_d       = 1'b1;
            gap_load_o = 1'b1;
            st_d       = ST_GAP_B;
          end else begin
            st_d = ST_PP_REQ;
          end
        end
      end
      ST_GAP_B: begin
        if (gap_zero_i) begin
          cs_d = 1'b0;
          st_d = ST_RS_OP;
        end
      end
      ST_RS_OP: begin
        eng_load_o = 1'b1;
        eng_data_o = OPC_RDSR;
        st_d       = ST_RS_CMD;
      end
      ST_RS_CMD: begin
        if (eng_last_i) begin
          eng_load_o = 1'b1;
          to_load_o  = 1'b1;
          st_d       = ST_RS_POLL;
        end
      end
      ST_RS_POLL: begin
        if (eng_last_i) begin
          if (!miso_i || to_zero_i) begin
            cs_d   = 1'b1;
            busy_d = 1'b0;
            done_d = 1'b1;
            errt_d = miso_i;
            st_d   = ST_IDLE;
          end else begin
            eng_load_o = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      cnt_q  <= '0;
      sent_q <= '0;
      hidx_q <= '0;
      cs_q   <= 1'b1;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      errc_q <= 1'b0;
      errt_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
      sent_q <= sent_d;
      hidx_q <= hidx_d;
      cs_q   <= cs_d;
      busy_q <= busy_d;
      done_q <= done_d;
      errc_q <= errc_d;
      errt_q <= errt_d;
    end
  end

  assign cs_n_o = cs_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign errc_o = errc_q;
  assign errt_o = errt_q;
endmodule

// File: rtl/spf_page_writer.sv
module spf_page_writer
  import spf_pkg::*;
#(
  parameter int PAGE_BYTES  = 256,
  parameter int GAP_CYC     = 4,
  parameter int TIMEOUT_CYC = 1000000,
  localparam int CNT_W  = $clog2(PAGE_BYTES) + 1,
  localparam int ADDR_W = ADDR_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  byte_count,
  output logic              src_req,
  input  logic              src_vld,
  input  logic [BYTE_W-1:0] src_data,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              busy,
  output logic              done,
  output logic              err_count,
  output logic              err_timeout
);
  localparam int GAP_W = $clog2(GAP_CYC + 1);
  localparam int TO_W  = $clog2(TIMEOUT_CYC + 1);

  logic [1:0]        rsync_q;
  logic              rst_int_n;
  logic              eng_load, eng_last;
  logic [BYTE_W-1:0] eng_data;
  logic              gap_load, gap_zero;
  logic              to_load, to_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rsync_q[1];

  spf_bit_engine #(.WORD_W(BYTE_W)) u_eng (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (eng_load),
    .data_i (eng_data),
    .sck_o  (spi_sck),
    .mosi_o (spi_mosi),
    .last_o (eng_last)
  );

  spf_down_counter #(.W(GAP_W)) u_gap (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_i  (gap_load),
    .value_i (GAP_W'(GAP_CYC - 1)),
    .en_i    (1'b1),
    .zero_o  (gap_zero)
  );

  spf_down_counter #(.W(TO_W)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_i  (to_load),
    .value_i (TO_W'(TIMEOUT_CYC)),
    .en_i    (1'b1),
    .zero_o  (to_zero)
  );

  spf_seq_ctrl #(.PAGE_BYTES(PAGE_BYTES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (start),
    .addr_i     (start_addr),
    .count_i    (byte_count),
    .vld_i      (src_vld),
    .data_i     (src_data),
    .miso_i     (spi_miso),
    .eng_last_i (eng_last),
    .gap_zero_i (gap_zero),
    .to_zero_i  (to_zero),
    .eng_load_o (eng_load),
    .eng_data_o (eng_data),
    .gap_load_o (gap_load),
    .to_load_o  (to_load),
    .req_o      (src_req),
    .cs_n_o     (spi_cs_n),
    .busy_o     (busy),
    .done_o     (done),
    .errc_o     (err_count),
    .errt_o     (err_timeout)
  );
endmodule

// File: rtl/spf_page_writer_chk.sv
module spf_page_writer_chk (
  input logic clk,
  input logic rst_n,
  input logic spi_cs_n,
  input logic spi_sck,
  input logic spi_mosi,
  input logic src_req,
  input logic busy,
  input logic done,
  input logic err_count,
  input logic err_timeout
);
  AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck); // R6
  AST_MOSI_HELD_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> $stable(spi_mosi)); // R6
  AST_SCK_ONE_CYCLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck) |=> !spi_sck); // R6
  AST_REQ_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    src_req |-> !spi_cs_n); // R5
  AST_ERR_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count || err_timeout) |-> done); // R2
  AST_DONE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> spi_cs_n); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_BUSY_FALL_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R10
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
endmodule

bind spf_page_writer spf_page_writer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .spi_cs_n    (spi_cs_n),
  .spi_sck     (spi_sck),
  .spi_mosi    (spi_mosi),
  .src_req     (src_req),
  .busy        (busy),
  .done        (done),
  .err_count   (err_count),
  .err_timeout (err_timeout)
);

// File: tb/spf_page_writer_tb_top.sv
module spf_page_writer_tb_top;
  localparam int TMO = 3000;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [23:0] start_addr;
  logic [8:0]  byte_count;
  logic        src_req;
  logic        src_vld;
  logic [7:0]  src_data;
  logic        spi_cs_n, spi_sck, spi_mosi, spi_miso;
  logic        busy, done, err_count, err_timeout;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  // flash model state
  logic [7:0] mem [0:4095];
  logic [7:0] exp_mem [0:4095];
  logic [7:0] fr_bytes [0:3][0:271];
  int   fr_bits [0:3];
  int   fr_end [0:3];
  int   fr_fall [0:3];
  int   fn = 0;
  int   nbits = 0;
  logic [7:0] sh = 8'h00;
  logic cs_p = 1'b1;
  logic sck_p = 1'b0;
  logic wel = 1'b0;
  int   fl_busy = 0;
  int   busy_dur = 0;
  int   busy_end_cyc = 0;
  int   last_fall = 0;
  int   bad_sck = 0;

  // byte source
  logic [7:0] src_mem [0:255];
  int src_idx = 0;
  int src_wait = 0;

  spf_page_writer #(.TIMEOUT_CYC(TMO)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_addr  (start_addr),
    .byte_count  (byte_count),
    .src_req     (src_req),
    .src_vld     (src_vld),
    .src_data    (src_data),
    .spi_cs_n    (spi_cs_n),
    .spi_sck     (spi_sck),
    .spi_mosi    (spi_mosi),
    .spi_miso    (spi_miso),
    .busy        (busy),
    .done        (done),
    .err_count   (err_count),
    .err_timeout (err_timeout)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // flash model, evaluated away from the active edge
  always @(negedge clk) begin
    if (fl_busy > 0) begin
      fl_busy--;
      if (fl_busy == 0) busy_end_cyc = cyc;
    end
    if (cs_p && !spi_cs_n) begin
      nbits = 0;
    end
    if (!spi_cs_n && spi_sck && !sck_p) begin
      sh = {sh[6:0], spi_mosi};
      nbits++;
      if ((nbits % 8 == 0) && fn < 4 && (nbits / 8) <= 272) fr_bytes[fn][nbits/8-1] = sh;
    end
    if (spi_sck && sck_p) bad_sck++;
    if (!spi_sck && sck_p) begin
      last_fall = cyc;
      if (fn < 4 && nbits >= 8 && fr_bytes[fn][0] == 8'h05) spi_miso = (fl_busy > 0);
    end
    if (!cs_p && spi_cs_n && fn < 4) begin
      fr_bits[fn] = nbits;
      fr_end[fn]  = cyc;
      fr_fall[fn] = last_fall;
      if (nbits == 8 && fr_bytes[fn][0] == 8'h06) wel = 1'b1;
      if (fr_bytes[fn][0] == 8'h02 && wel && (nbits % 8 == 0) && nbits >= 40) begin
        int nb, first;
        nb = nbits / 8 - 4;
        first = (nb > 256) ? nb - 256 : 0;
        for (int i = first; i < nb; i++) begin
          logic [7:0] off;
          off = fr_bytes[fn][3] + 8'(i - first);
          mem[{fr_bytes[fn][2][3:0], off}] = mem[{fr_bytes[fn][2][3:0], off}] & fr_bytes[fn][4+i];
        end
        wel = 1'b0;
        fl_busy = busy_dur;
      end
      fn++;
    end
    cs_p  = spi_cs_n;
    sck_p = spi_sck;
  end

  // byte source with random stalls
  always @(negedge clk) begin
    src_vld = 1'b0;
    if (src_req) begin
      if (src_wait == 0) begin
        src_vld  = 1'b1;
        src_data = src_mem[src_idx[7:0]];
        src_idx++;
        src_wait = $urandom % 3;
      end else begin
        src_wait--;
      end
    end
  end

  task automatic do_op(input logic [23:0] a, input int n, input int bdur,
                       input bit poke, input bit exp_to);
    int k, done_cyc, busy_bad, errc_seen;
    bit got, e_c, e_t, ok;
    for (int i = 0; i < 256; i++) src_mem[i] = 8'($urandom);
    src_idx = 0; src_wait = 0; fn = 0; busy_dur = bdur; busy_end_cyc = 0;
    if (n >= 1 && n <= 256) begin
      for (int i = 0; i < n; i++) begin
        logic [7:0] o;
        o = a[7:0] + 8'(i);
        exp_mem[{a[11:8], o}] = exp_mem[{a[11:8], o}] & src_mem[i];
      end
    end
    start = 1'b1; start_addr = a; byte_count = 9'(n);
    @(negedge clk);
    start = 1'b0;
    k = 0; busy_bad = 0; errc_seen = 0;
    while (!done && k < 60000) begin
      if (!busy) busy_bad++;
      if (err_count) errc_seen++;
      if (poke && k == 60) begin start = 1'b1; byte_count = 9'd0; start_addr = ~a; end
      else start = 1'b0;
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    got = done; e_c = err_count; e_t = err_timeout; done_cyc = cyc;
    check(got, "R10 done seen", int'(got), 1);
    check(!busy, "R10 busy low in done cycle", int'(busy), 0);
    @(negedge clk);
    check(!done, "R10 done single cycle", int'(done), 0);
    if (n < 1 || n > 256) begin
      check(k == 0, "R2 reject latency", k, 0);
      check(e_c && !e_t, "R2 count error flag", int'(e_c), 1);
      repeat (4) @(negedge clk);
      check(fn == 0 && spi_cs_n, "R2 no frame opened", fn, 0);
      return;
    end
    check(!e_c, "R2 no count error on valid count", int'(e_c), 0);
    check(busy_bad == 0, "R10 busy held until done", busy_bad, 0);
    check(errc_seen == 0, "R9 start ignored while busy", errc_seen, 0);
    check(fn == 3, "R3 frame count", fn, 3);
    check(fr_bits[0] == 8 && fr_bytes[0][0] == 8'h06, "R3 write-enable frame",
          int'(fr_bytes[0][0]), 6);
    check(fr_end[0] - fr_fall[0] <= 1, "R3 chip select raised at once",
          fr_end[0] - fr_fall[0], 0);
    check(fr_bits[1] == (4 + n) * 8, "R4 program frame length", fr_bits[1], (4 + n) * 8);
    ok = (fr_bytes[1][0] == 8'h02) && (fr_bytes[1][1] == a[23:16]) &&
         (fr_bytes[1][2] == a[15:8]) && (fr_bytes[1][3] == a[7:0]);
    check(ok, "R4 opcode and address", int'(fr_bytes[1][3]), int'(a[7:0]));
    begin
      int mis = 0;
      for (int i = 0; i < n; i++) if (fr_bytes[1][4+i] != src_mem[i]) mis++;
      check(mis == 0, "R4 payload order", mis, 0);
      mis = 0;
      for (int i = 0; i < 256; i++)
        if (mem[{a[11:8], 8'(i)}] != exp_mem[{a[11:8], 8'(i)}]) mis++;
      check(mis == 0, "R4 page content with wrap", mis, 0);
    end
    check(src_idx == n, "R5 handshake count", src_idx, n);
    check(fr_bytes[2][0] == 8'h05 && fr_bits[2] >= 16 && (fr_bits[2] % 8 == 0),
          "R7 status frame shape", fr_bits[2], 16);
    check(bad_sck == 0, "R6 serial clock high width", bad_sck, 0);
    if (exp_to) begin
      check(e_t, "R8 timeout flag", int'(e_t), 1);
      check(fl_busy > 0, "R8 ended while flash busy", fl_busy, 1);
      check(done_cyc - fr_end[1] >= TMO, "R8 not before limit", done_cyc - fr_end[1], TMO);
      k = 0;
      while (fl_busy > 0 && k < 20000) begin @(negedge clk); k++; end
    end else begin
      check(!e_t, "R8 no timeout", int'(e_t), 0);
      check(busy_end_cyc > 0 && done_cyc >= busy_end_cyc && done_cyc - busy_end_cyc <= 40,
            "R7 done follows busy end", done_cyc - busy_end_cyc, 20);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 4096; i++) begin mem[i] = 8'hFF; exp_mem[i] = 8'hFF; end
    spi_miso = 1'b0; src_vld = 1'b0; src_data = 8'h00;
    start = 1'b0; start_addr = '0; byte_count = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(spi_cs_n && !spi_sck && !busy && !done && !src_req, "R1 state in reset",
          int'(spi_cs_n), 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(spi_cs_n && !spi_sck && !busy && !done && !err_count && !err_timeout && !src_req,
          "R1 state after release", int'(busy), 0);
    do_op(24'h012300, 256, 300, 1'b0, 1'b0);   // full page, aligned
    do_op(24'h0456F0, 32, 120, 1'b0, 1'b0);    // crosses page end: wraps
    do_op(24'h000A7F, 1, 40, 1'b0, 1'b0);      // single byte
    do_op(24'h000200, 0, 40, 1'b0, 1'b0);      // R2 zero count
    do_op(24'h000200, 257, 40, 1'b0, 1'b0);    // R2 oversize count
    do_op(24'h0A0B10, 64, 200, 1'b1, 1'b0);    // R9 start during operation
    do_op(24'h000C40, 16, 8000, 1'b0, 1'b1);   // R8 flash stays busy
    for (int r = 0; r < 6; r++) begin
      do_op(24'($urandom), 1 + int'($urandom % 256), 40 + int'($urandom % 400), 1'b0, 1'b0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule